// File: doc/BRIEF.md
# I2C Target Address Matcher

This block decides, byte by byte, whether an I2C target claims a transfer. A bit engine gives it START (repeated START included) and STOP pulses and each received byte with a one-cycle strobe. The block compares the byte against a programmed 10-bit device ID, using either 7-bit or 10-bit addressing. It registers an acknowledge decision that the bit engine drives on the ninth clock. It also keeps the status flags that software reads after an address phase. Serialisation, line filtering and the data FIFO sit outside the block. Only the FIFO's full state comes in, so that received data can be refused.

Address acknowledges need a software arm bit. The arm bit can drop by itself once a start sequence has been acknowledged, so every new start needs a fresh arm. The addressed flag is kept apart from the acknowledged state. Software can therefore see a master that called this target while the target was not armed.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: In 7-bit mode (`ten_bit_i`=0), the first byte after START matches when byte[7:1] equals `dev_id_i`[6:0]. ID bits 9..7 are ignored. A match is acknowledged only when `arm_o` is 1. The decision for a byte strobed in cycle t appears in cycle t+1 as `ack_vld_o`=1, with `ack_o` carrying 1 for acknowledge.
- R2: In 10-bit mode, a first byte of 11110, `dev_id_i`[9:8], 0 is acknowledged when armed. The next byte must equal `dev_id_i`[7:0]. If it does and the block is armed, that byte is acknowledged and `ten_ack_o` is set. Any other first byte in 10-bit mode is not acknowledged.
- R3: A first byte that does not match is not acknowledged and leaves `addressed_o` at 0. A matching address sets `addressed_o` even when it is not acknowledged.
- R4: `arm_o` is set by `arm_set_i` and cleared by `arm_clr_i`. When `arm_auto_i`=1, it also clears once an address sequence is acknowledged. When `arm_auto_i`=0, it stays set.
- R5: A first byte of 0x00 is a general call. It is acknowledged, and `gcall_ack_o` is set, only when `gcall_en_i`=1. `gcall_ack_o` clears on any later first byte that is not an acknowledged general call.
- R6: `addressed_o` clears on every START and every STOP.
- R7: `dir_o` takes bit 0 of each first byte and is forced to 0 at every START. `dir_ack_o` changes only when an address sequence is acknowledged. A general call counts as a write. A completed 10-bit write sequence also counts as a write.
- R8: After an acknowledged write address, a data byte is acknowledged only when `rx_ack_en_i`=1 and `fifo_full_i`=0. Bytes after an unacknowledged address are never acknowledged.
- R9: A one-cycle `flag_rst_i` clears `addressed_o`, `dir_o`, `dir_ack_o`, `gcall_ack_o` and `ten_ack_o`, and returns the block to idle. Bytes before the next START are then not acknowledged.
- R10: A matching address sets `sreq_pulse_o` for one cycle and sets `sreq_o`. `sreq_o` stays set until `irq_clr_i`.
- R11: After an acknowledged 10-bit write sequence, a repeated START followed by 11110, ID[9:8], 1 matches in one byte. It is acknowledged when armed, with `dir_ack_o` and `ten_ack_o` set. After a STOP, that same byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen |
| stop_i | input | 1 | STOP seen |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| dev_id_i | input | 10 | Device ID |
| ten_bit_i | input | 1 | 1: 10-bit addressing |
| arm_set_i | input | 1 | Set the address acknowledge arm |
| arm_clr_i | input | 1 | Clear the arm |
| arm_auto_i | input | 1 | Clear the arm after an acknowledged address |
| gcall_en_i | input | 1 | Acknowledge general calls |
| rx_ack_en_i | input | 1 | Acknowledge received data |
| fifo_full_i | input | 1 | Receive FIFO full |
| flag_rst_i | input | 1 | Clear status flags |
| irq_clr_i | input | 1 | Clear sticky request |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1: pull SDA low on ninth clock |
| sreq_pulse_o | output | 1 | One-cycle target request |
| sreq_o | output | 1 | Sticky target request |
| arm_o | output | 1 | Arm state |
| addressed_o | output | 1 | Address matched in this frame |
| dir_o | output | 1 | R/W bit of last first byte |
| dir_ack_o | output | 1 | Direction of last acknowledged address |
| gcall_ack_o | output | 1 | General call acknowledged |
| ten_ack_o | output | 1 | 10-bit address acknowledged |

## Verification
On every cycle, the assertions check the following:
- the clearing effect of START, STOP and the flag reset;
- that every decision follows a strobe;
- that a general-call flag only rises on a 0x00 byte with the enable set;
- that the arm falls only through its clear input or an automatic clear together with an acknowledged match;
- that the request pulse is single and backed by the sticky bit.

The actual match results need the bench's scripted frames. These are the ignored ID bits, the two-byte 10-bit sequence, the read re-address after a repeated START and its loss at STOP, and the refusal of data when the FIFO is full.

// File: rtl/i2c_tam_pkg.sv
package i2c_tam_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_HDR = 5'b11110;
  localparam logic [BYTE_W-1:0] GCALL_BYTE = '0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_ADDR2, PH_RX, PH_TX, PH_SKIP
  } phase_e;

  typedef struct packed {
    logic gcall;
    logic hit7;
    logic hit10_hi;
    logic hit10_lo;
  } cmp_t;
endpackage

// File: rtl/i2c_tam_cmp.sv
module i2c_tam_cmp
  import i2c_tam_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ID_W-1:0]   id_i,
  output cmp_t              cmp_o
);
  localparam int A7_W = BYTE_W - 1;

  always_comb begin
    cmp_o.gcall    = (byte_i == GCALL_BYTE);
    cmp_o.hit7     = (byte_i[BYTE_W-1:1] == id_i[A7_W-1:0]);
    cmp_o.hit10_hi = (byte_i[BYTE_W-1:3] == TEN_HDR) && (byte_i[2:1] == id_i[ID_W-1:ID_W-2]);
    cmp_o.hit10_lo = (byte_i == id_i[BYTE_W-1:0]);
  end
endmodule

// File: rtl/i2c_tam_arm.sv
module i2c_tam_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic auto_i,
  input  logic adr_ack_i,
  output logic arm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                arm_o <= 1'b0;
    else if (set_i)             arm_o <= 1'b1;
    else if (clr_i)             arm_o <= 1'b0;
    else if (auto_i && adr_ack_i) arm_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_tam_irq.sv
module i2c_tam_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic sticky_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o  <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      pulse_o <= hit_i;
      if (hit_i)      sticky_o <= 1'b1;
      else if (clr_i) sticky_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import i2c_tam_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ID_W-1:0]   dev_id_i,
  input  logic              ten_bit_i,
  input  logic              arm_set_i,
  input  logic              arm_clr_i,
  input  logic              arm_auto_i,
  input  logic              gcall_en_i,
  input  logic              rx_ack_en_i,
  input  logic              fifo_full_i,
  input  logic              flag_rst_i,
  input  logic              irq_clr_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              sreq_pulse_o,
  output logic              sreq_o,
  output logic              arm_o,
  output logic              addressed_o,
  output logic              dir_o,
  output logic              dir_ack_o,
  output logic              gcall_ack_o,
  output logic              ten_ack_o
);
  phase_e phase_q, phase_d;
  cmp_t   cmp;
  logic   ten_sel_q;
  logic   byte_ok, is_a1, is_a2, is_rx;
  logic   gc_ack, m7, wr10a, rd10, m10b, hit, adr_ack, ack_d, rw;

  i2c_tam_cmp #(.ID_W(ID_W)) u_cmp (.byte_i(byte_i), .id_i(dev_id_i), .cmp_o(cmp));

  i2c_tam_arm u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(arm_set_i), .clr_i(arm_clr_i),
    .auto_i(arm_auto_i), .adr_ack_i(adr_ack), .arm_o(arm_o)
  );

  i2c_tam_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .clr_i(irq_clr_i),
    .pulse_o(sreq_pulse_o), .sticky_o(sreq_o)
  );

  // bus events and flag reset take precedence over a byte in the same cycle
  assign byte_ok = byte_vld_i && !start_i && !stop_i && !flag_rst_i;
  assign is_a1   = byte_ok && (phase_q == PH_ADDR);
  assign is_a2   = byte_ok && (phase_q == PH_ADDR2);
  assign is_rx   = byte_ok && (phase_q == PH_RX);
  assign rw      = byte_i[0];

  always_comb begin
    gc_ack  = is_a1 && cmp.gcall && gcall_en_i;
    m7      = is_a1 && !ten_bit_i && !cmp.gcall && cmp.hit7;
    wr10a   = is_a1 && ten_bit_i && cmp.hit10_hi && !rw;
    rd10    = is_a1 && ten_bit_i && cmp.hit10_hi && rw && ten_sel_q;
    m10b    = is_a2 && cmp.hit10_lo;
    hit     = m7 || rd10 || m10b;
    adr_ack = hit && arm_o;
    ack_d   = adr_ack || gc_ack || (wr10a && arm_o) ||
              (is_rx && rx_ack_en_i && !fifo_full_i);

    phase_d = phase_q;
    if (is_a1) begin
      if (gc_ack)               phase_d = PH_RX;
      else if (m7 || rd10)      phase_d = adr_ack ? (rw ? PH_TX : PH_RX) : PH_SKIP;
      else if (wr10a && arm_o)  phase_d = PH_ADDR2;
      else                      phase_d = PH_SKIP;
    end else if (is_a2) begin
      phase_d = adr_ack ? PH_RX : PH_SKIP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      ten_sel_q   <= 1'b0;
      addressed_o <= 1'b0;
      dir_o       <= 1'b0;
      dir_ack_o   <= 1'b0;
      gcall_ack_o <= 1'b0;
      ten_ack_o   <= 1'b0;
    end else if (flag_rst_i) begin
      phase_q     <= PH_IDLE;
      ten_sel_q   <= 1'b0;
      addressed_o <= 1'b0;
      dir_o       <= 1'b0;
      dir_ack_o   <= 1'b0;
      gcall_ack_o <= 1'b0;
      ten_ack_o   <= 1'b0;
    end else if (start_i) begin
      phase_q     <= PH_ADDR;
      addressed_o <= 1'b0;
      dir_o       <= 1'b0;
    end else if (stop_i) begin
      phase_q     <= PH_IDLE;
      addressed_o <= 1'b0;
      ten_sel_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (is_a1) begin
        dir_o       <= rw;
        gcall_ack_o <= gc_ack;
        ten_ack_o   <= 1'b0;
        ten_sel_q   <= rd10;
      end
      if (hit) addressed_o <= 1'b1;
      if (gc_ack) dir_ack_o <= 1'b0;
      if (adr_ack) begin
        dir_ack_o   <= is_a2 ? 1'b0 : rw;
        ten_ack_o   <= rd10 || m10b;
        gcall_ack_o <= 1'b0;
      end
      if (m10b && adr_ack) ten_sel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      ack_vld_o <= byte_ok;
      ack_o     <= byte_ok && ack_d;
    end
  end
endmodule

// File: rtl/i2c_tgt_addr_match_chk.sv
module i2c_tgt_addr_match_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_vld_i,
  input logic [7:0] byte_i,
  input logic       arm_clr_i,
  input logic       arm_auto_i,
  input logic       gcall_en_i,
  input logic       flag_rst_i,
  input logic       ack_vld_o,
  input logic       ack_o,
  input logic       sreq_pulse_o,
  input logic       sreq_o,
  input logic       arm_o,
  input logic       addressed_o,
  input logic       dir_o,
  input logic       dir_ack_o,
  input logic       gcall_ack_o,
  input logic       ten_ack_o
);
  a_r6_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !addressed_o && !dir_o);
  a_r6_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !addressed_o);
  a_r9_flag_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_rst_i |=> !addressed_o && !dir_o && !dir_ack_o && !gcall_ack_o && !ten_ack_o);
  a_r1_decision_follows_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> $past(byte_vld_i));
  a_r5_gcall_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gcall_ack_o) |-> $past(gcall_en_i) && ($past(byte_i) == 8'h00) && ack_o);
  a_r4_arm_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arm_o) |-> $past(arm_clr_i) || ($past(arm_auto_i) && sreq_pulse_o && ack_o));
  a_r10_pulse_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreq_pulse_o |-> sreq_o);
  a_r10_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreq_pulse_o |=> !sreq_pulse_o);
endmodule

bind i2c_tgt_addr_match i2c_tgt_addr_match_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .byte_vld_i(byte_vld_i), .byte_i(byte_i), .arm_clr_i(arm_clr_i),
  .arm_auto_i(arm_auto_i), .gcall_en_i(gcall_en_i), .flag_rst_i(flag_rst_i),
  .ack_vld_o(ack_vld_o), .ack_o(ack_o), .sreq_pulse_o(sreq_pulse_o),
  .sreq_o(sreq_o), .arm_o(arm_o), .addressed_o(addressed_o), .dir_o(dir_o),
  .dir_ack_o(dir_ack_o), .gcall_ack_o(gcall_ack_o), .ten_ack_o(ten_ack_o)
);

// File: tb/i2c_tgt_addr_match_bench.sv
module i2c_tgt_addr_match_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, bvld = 0, ten = 0;
  logic arm_set = 0, arm_clr = 0, arm_auto = 0, gc_en = 0, rx_en = 0, full = 0;
  logic frst = 0, iclr = 0;
  logic [7:0] bdat = '0;
  logic [9:0] id = 10'h2A5;
  logic ack_vld, ack, sreq_p, sreq, arm, addr, dir, dir_ack, gc_ack, ten_ack;
  int n_vec = 0, n_bad = 0;
  bit exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  i2c_tgt_addr_match u_i2c_tgt_addr_match (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_vld_i(bvld), .byte_i(bdat), .dev_id_i(id), .ten_bit_i(ten),
    .arm_set_i(arm_set), .arm_clr_i(arm_clr), .arm_auto_i(arm_auto),
    .gcall_en_i(gc_en), .rx_ack_en_i(rx_en), .fifo_full_i(full),
    .flag_rst_i(frst), .irq_clr_i(iclr), .ack_vld_o(ack_vld), .ack_o(ack),
    .sreq_pulse_o(sreq_p), .sreq_o(sreq), .arm_o(arm), .addressed_o(addr),
    .dir_o(dir), .dir_ack_o(dir_ack), .gcall_ack_o(gc_ack), .ten_ack_o(ten_ack)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected decision per valid
  always @(negedge clk) begin
    if (rst_n && ack_vld) begin
      if (exp_q.size() == 0) chk("R1 unexpected decision", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {31'd0, ack}, {31'd0, e});
      end
    end
  end

  task automatic send(logic [7:0] b, bit e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk) begin bvld = 1; bdat = b; end
    @(negedge clk) bvld = 0;
  endtask

  task automatic p_start; @(negedge clk) start = 1; @(negedge clk) start = 0; endtask
  task automatic p_stop;  @(negedge clk) stop = 1;  @(negedge clk) stop = 0;  endtask
  task automatic p_arm;   @(negedge clk) arm_set = 1; @(negedge clk) arm_set = 0; endtask
  task automatic p_disarm; @(negedge clk) arm_clr = 1; @(negedge clk) arm_clr = 0; endtask
  task automatic p_frst;  @(negedge clk) frst = 1;  @(negedge clk) frst = 0;  endtask
  task automatic p_iclr;  @(negedge clk) iclr = 1;  @(negedge clk) iclr = 0;  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk("watchdog", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset flags", {addr, dir, dir_ack, gc_ack, ten_ack, arm, sreq, ack_vld}, 0);

    // unarmed match: addressed but refused, request raised
    p_start; send(8'h4A, 0, "R1 unarmed match ack");
    chk("R3 addressed unarmed", addr, 1);
    chk("R10 sticky set", sreq, 1);
    send(8'h11, 0, "R8 data after refused addr");
    p_stop; chk("R6 stop clears", addr, 0);
    chk("R10 sticky holds", sreq, 1);
    p_iclr; chk("R10 sticky cleared", sreq, 0);

    // upper ID bits ignored in 7-bit mode, auto disarm, data gating
    id = 10'h3A5; arm_auto = 1; p_arm;
    p_start; send(8'h4A, 1, "R1 armed match ack");
    chk("R4 auto disarm", arm, 0);
    rx_en = 1; send(8'h33, 1, "R8 data acked");
    full = 1;  send(8'h44, 0, "R8 fifo full refuses");
    full = 0; rx_en = 0; send(8'h55, 0, "R8 rx disabled refuses");
    rx_en = 1; p_stop; id = 10'h2A5;

    // mismatch
    p_arm; p_start; send(8'h4C, 0, "R3 mismatch ack");
    chk("R3 mismatch not addressed", addr, 0);
    chk("R4 arm kept on mismatch", arm, 1);
    p_stop;

    // direction, no auto disarm
    arm_auto = 0;
    p_start; send(8'h4B, 1, "R1 read match ack");
    chk("R7 dir read", dir, 1); chk("R7 dir_ack read", dir_ack, 1);
    chk("R4 arm kept without auto", arm, 1);
    p_start;
    chk("R7 dir forced at start", dir, 0); chk("R6 start clears", addr, 0);
    chk("R7 dir_ack holds", dir_ack, 1);
    send(8'h4A, 1, "R1 rstart write ack");
    chk("R7 dir_ack write", dir_ack, 0);
    p_stop; p_disarm;
    p_start; send(8'h4B, 0, "R1 disarmed read ack");
    chk("R7 dir from unacked", dir, 1); chk("R7 dir_ack unchanged", dir_ack, 0);
    p_stop; p_iclr;

    // general call
    p_start; send(8'h00, 0, "R5 gcall disabled");
    chk("R5 gcall flag off", gc_ack, 0);
    gc_en = 1; p_start; send(8'h00, 1, "R5 gcall acked");
    chk("R5 gcall flag on", gc_ack, 1);
    chk("R10 no request on gcall", sreq, 0);
    send(8'h5A, 1, "R8 gcall data acked");
    p_start; send(8'h4C, 0, "R5 later mismatch");
    chk("R5 gcall flag cleared", gc_ack, 0);
    p_stop; gc_en = 0;

    // 10-bit addressing
    ten = 1; arm_auto = 1; p_arm;
    p_start; send(8'hF4, 1, "R2 first byte ack");
    chk("R2 not yet addressed", addr, 0); chk("R2 arm kept after first", arm, 1);
    send(8'hA5, 1, "R2 second byte ack");
    chk("R2 ten_ack set", ten_ack, 1); chk("R2 addressed", addr, 1);
    chk("R4 auto disarm 10-bit", arm, 0);
    p_start; p_arm; send(8'hF5, 1, "R11 read readdress ack");
    chk("R11 dir_ack read", dir_ack, 1); chk("R11 ten_ack", ten_ack, 1);
    chk("R11 addressed", addr, 1);
    p_stop; p_arm;
    p_start; send(8'hF5, 0, "R11 read after stop refused");
    chk("R11 not addressed", addr, 0); chk("R11 ten_ack cleared", ten_ack, 0);
    p_start; send(8'hF4, 1, "R2 first byte again");
    send(8'hA6, 0, "R2 low byte mismatch");
    chk("R2 mismatch no ten_ack", ten_ack, 0); chk("R2 mismatch not addressed", addr, 0);
    p_start; send(8'h4A, 0, "R2 7-bit form in 10-bit mode");
    p_stop; ten = 0;

    // flag reset
    p_start; send(8'h4B, 1, "R9 setup ack");
    chk("R9 setup addressed", addr, 1);
    p_frst;
    chk("R9 flags cleared", {addr, dir, dir_ack, gc_ack, ten_ack}, 0);
    send(8'h77, 0, "R9 idle after reset");

    repeat (3) @(negedge clk);
    chk("R1 all decisions seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule